// File: doc/BRIEF.md
# Random Number Controller Register Block

This block is a memory-mapped controller for a random word source. Software talks to it through a single-cycle register port. It can start a self-test or a seed operation, each of which lasts a parameterised number of cycles. It can mask the done and error interrupts, and it can clear either the interrupt or the error state. Once a seed has completed cleanly, a pseudo-random generator fills an output FIFO, and software pops 32-bit words from that FIFO.

A stand-in generator produces the words: a 32-bit xorshift stepped from a fixed start value. The test hook `stat_err_inject` lets a seed operation end with a statistical-error code. Software is expected to clear that code and retry the seed. The two clear commands behave differently. Clearing the interrupt has no effect while an error code is held. Clearing the error wipes the error code and the done flags together.

Top module: `rng_ctrl_top`

## Requirements
- R1: After reset, irq is 0, and the status, error and control registers all read as zero with a FIFO level of 0.
- R2: The registers sit at byte offsets command 0x04, control 0x08, status 0x0C, error 0x10 and FIFO 0x14. The control register reads back only bit 5 (done mask) and bit 6 (error mask). The command register and unmapped offsets always read 0.
- R3: Writing command bit 0 starts a self-test. Exactly TEST_CYC cycles after the write edge, status bit 4 becomes 1, and irq rises unless control bit 5 is set.
- R4: Writing command bit 1 starts a seed operation, which sets status bit 5 after SEED_CYC cycles. If stat_err_inject is high on the completion cycle, the error register becomes 0x8 (bit 3) and status bit 16 becomes 1.
- R5: An operation command written while an operation is running has no effect. If bits 0 and 1 are written together, only the self-test starts.
- R6: Command bit 4 clears status bits 4 and 5 and the done interrupt, but only when the error register is zero. Otherwise it has no effect.
- R7: Command bit 5 zeroes the error register, clears status bits 4 and 5, and drops irq.
- R8: A nonzero error register drives irq high unless control bit 6 is set.
- R9: After the first clean seed, the FIFO fills to DEPTH (15) words. Status bits 11:8 report the level. The words are successive xorshift32 states (x^=x<<13, x^=x>>17, x^=x<<5) that start from INIT.
- R10: A read at 0x14 with a nonzero level returns the oldest word and lowers the level by one.
- R11: A read at 0x14 with level 0 returns 0, sets error bit 2 and status bit 16, and leaves the level at 0.
- R12: While the error register is nonzero, no words are generated. Generation resumes after a clear-error command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a FIFO read pops) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| irq | output | 1 | Interrupt request |
| stat_err_inject | input | 1 | Test hook: fail the seed that completes in this cycle |

## Verification
The hardest state to reach is an error arriving while the FIFO is already full of words from an earlier good seed. Only in that state can the halt of generation be told apart from a FIFO that is merely full. The stimulus reaches it by completing a clean seed and then running a second seed with the injection hook raised. It then drains all fifteen words while the error is held, checks that the level stays at zero, and checks that refilling starts only after the clear-error command. Word order is checked against a bench-side xorshift sequence through both directed pops and randomly timed pops.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
    localparam int REG_AW = 8;
    localparam int DATA_W = 32;
    localparam int ERR_W  = 4;

    localparam logic [REG_AW-1:0] A_CMD  = 8'h04;
    localparam logic [REG_AW-1:0] A_CTRL = 8'h08;
    localparam logic [REG_AW-1:0] A_STAT = 8'h0C;
    localparam logic [REG_AW-1:0] A_ERR  = 8'h10;
    localparam logic [REG_AW-1:0] A_FIFO = 8'h14;

    localparam int CMD_TEST  = 0;
    localparam int CMD_SEED  = 1;
    localparam int CMD_CLRI  = 4;
    localparam int CMD_CLRE  = 5;
    localparam int CTL_MDONE = 5;
    localparam int CTL_MERR  = 6;
    localparam int ST_TDONE  = 4;
    localparam int ST_SDONE  = 5;
    localparam int ST_LVL    = 8;
    localparam int ST_ERR    = 16;
    localparam int ER_EMPTY  = 2;
    localparam int ER_STAT   = 3;

    typedef enum logic [1:0] {OP_IDLE, OP_TEST, OP_SEED} op_e;

    typedef struct packed {
        logic fire;
        op_e  kind;
    } op_evt_t;

    typedef struct packed {
        logic mask_err;
        logic mask_done;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] xs_step(input logic [DATA_W-1:0] s);
        logic [DATA_W-1:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input logic tdone, input logic sdone,
                                                      input logic err, input logic [3:0] lvl);
        logic [DATA_W-1:0] s;
        s = '0;
        s[ST_TDONE] = tdone;
        s[ST_SDONE] = sdone;
        s[ST_ERR]   = err;
        s[ST_LVL +: 4] = lvl;
        return s;
    endfunction
endpackage

// File: rtl/rngc_opseq.sv
module rngc_opseq
    import rngc_pkg::*;
#(
    parameter int TEST_CYC = 8,
    parameter int SEED_CYC = 12
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_test,
    input  logic    start_seed,
    output logic    busy,
    output op_evt_t done
);
    localparam int MAXC = (TEST_CYC > SEED_CYC) ? TEST_CYC : SEED_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    op_e           kind_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= OP_IDLE;
            cnt_q  <= '0;
        end else if (kind_q == OP_IDLE) begin
            if (start_test) begin
                kind_q <= OP_TEST;
                cnt_q  <= CW'(TEST_CYC);
            end else if (start_seed) begin
                kind_q <= OP_SEED;
                cnt_q  <= CW'(SEED_CYC);
            end
        end else begin
            if (cnt_q == CW'(1)) kind_q <= OP_IDLE;
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy      = (kind_q != OP_IDLE);
    assign done.fire = busy && (cnt_q == CW'(1));
    assign done.kind = kind_q;
endmodule

// File: rtl/rngc_wordgen.sv
module rngc_wordgen
    import rngc_pkg::*;
#(
    parameter logic [DATA_W-1:0] INIT = 32'h2545F491
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] state_q;

    assign word = xs_step(state_q);

    always_ff @(posedge clk) begin
        if (rst)          state_q <= INIT;
        else if (advance) state_q <= word;
    end
endmodule

// File: rtl/rngc_fifo.sv
module rngc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 15,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [LW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (cnt_q == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (cnt_q != '0);
    assign head    = mem[rp_q];
    assign level   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wrap_inc(wp_q);
            if (do_pop)  rp_q <= wrap_inc(rp_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + LW'(1);
            else if (do_pop && !do_push) cnt_q <= cnt_q - LW'(1);
        end
    end
endmodule

// File: rtl/rng_ctrl_top.sv
module rng_ctrl_top
    import rngc_pkg::*;
#(
    parameter int                TEST_CYC = 8,
    parameter int                SEED_CYC = 12,
    parameter int                DEPTH    = 15,
    parameter logic [DATA_W-1:0] INIT     = 32'h2545F491
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    input  logic              stat_err_inject
);
    localparam int LW = $clog2(DEPTH + 1);

    ctrl_t             ctrl_q;
    logic [ERR_W-1:0]  err_q, err_d;
    logic              tdone_q, sdone_q, seeded_q;
    logic              busy;
    op_evt_t           done;
    logic [DATA_W-1:0] gen_word, head;
    logic [LW-1:0]     lvl;
    logic              full, gen_push, fifo_pop, empty_rd;
    logic              wr_cmd, wr_ctrl, rd_fifo, clr_int, clr_err, err_any;
    logic              fin_test, fin_seed, seed_bad;

    assign wr_cmd   = wr_en && (addr == A_CMD);
    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign rd_fifo  = rd_en && (addr == A_FIFO);
    assign clr_int  = wr_cmd && wdata[CMD_CLRI];
    assign clr_err  = wr_cmd && wdata[CMD_CLRE];
    assign err_any  = (err_q != '0);
    assign fifo_pop = rd_fifo && (lvl != '0);
    assign empty_rd = rd_fifo && (lvl == '0);
    assign gen_push = seeded_q && !err_any && !full;
    assign fin_test = done.fire && (done.kind == OP_TEST);
    assign fin_seed = done.fire && (done.kind == OP_SEED);
    assign seed_bad = fin_seed && stat_err_inject;

    rngc_opseq #(.TEST_CYC(TEST_CYC), .SEED_CYC(SEED_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_test (wr_cmd && wdata[CMD_TEST]),
        .start_seed (wr_cmd && wdata[CMD_SEED]),
        .busy       (busy),
        .done       (done)
    );

    rngc_wordgen #(.INIT(INIT)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .advance (gen_push),
        .word    (gen_word)
    );

    rngc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (gen_push),
        .pop   (fifo_pop),
        .din   (gen_word),
        .head  (head),
        .level (lvl),
        .full  (full)
    );

    always_comb begin
        err_d = clr_err ? '0 : err_q;
        if (empty_rd) err_d[ER_EMPTY] = 1'b1;
        if (seed_bad) err_d[ER_STAT]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            err_q    <= '0;
            tdone_q  <= 1'b0;
            sdone_q  <= 1'b0;
            seeded_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.mask_done <= wdata[CTL_MDONE];
                ctrl_q.mask_err  <= wdata[CTL_MERR];
            end
            err_q <= err_d;
            if (clr_err || (clr_int && !err_any)) begin
                tdone_q <= 1'b0;
                sdone_q <= 1'b0;
            end
            if (fin_test) tdone_q <= 1'b1;
            if (fin_seed) sdone_q <= 1'b1;
            if (fin_seed && !stat_err_inject) seeded_q <= 1'b1;
        end
    end

    assign irq = ((tdone_q || sdone_q) && !ctrl_q.mask_done) ||
                 (err_any && !ctrl_q.mask_err);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_CTRL: begin
                    rdata[CTL_MDONE] = ctrl_q.mask_done;
                    rdata[CTL_MERR]  = ctrl_q.mask_err;
                end
                A_STAT:  rdata = pack_status(tdone_q, sdone_q, err_any, 4'(lvl));
                A_ERR:   rdata = DATA_W'(err_q);
                A_FIFO:  if (lvl != '0) rdata = head;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rngc_chk.sv
module rngc_chk
    import rngc_pkg::*;
#(
    parameter int DEPTH = 15,
    parameter int LW    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [REG_AW-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [LW-1:0]     lvl,
    input logic              busy,
    input logic [ERR_W-1:0]  err_reg
);
    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(lvl) <= DEPTH);

    // R2
    cmd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_CMD) |-> (rdata == '0));

    // R11
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_FIFO && lvl == '0) |-> (rdata == '0) ##1 err_reg[ER_EMPTY]);

    // R7
    clr_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CMD && wdata[CMD_CLRE] && !busy && !(rd_en && addr == A_FIFO))
        |=> (!irq && err_reg == '0));

    // R12
    halt_chk: assert property (@(posedge clk) disable iff (rst)
        (err_reg != '0 && !(rd_en && addr == A_FIFO)) |=> (lvl == $past(lvl)));
endmodule

bind rng_ctrl_top rngc_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .lvl     (lvl),
    .busy    (busy),
    .err_reg (err_q)
);

// File: tb/sim_rng_ctrl_top.sv
module sim_rng_ctrl_top;
    localparam int CLK_P    = 10;
    localparam int TEST_CYC = 8;
    localparam int SEED_CYC = 12;
    localparam logic [31:0] INIT = 32'h2545F491;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, inj = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, fails = 0;
    logic [31:0] exp_state = INIT;
    logic [31:0] v;
    logic        irq_s;
    bit          finished = 0;

    always #(CLK_P/2) clk = ~clk;

    rng_ctrl_top #(.TEST_CYC(TEST_CYC), .SEED_CYC(SEED_CYC), .DEPTH(15), .INIT(INIT)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .stat_err_inject(inj)
    );

    function automatic logic [31:0] next_word(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic iq);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1; d = rdata; iq = irq;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pop_expect(input string req);
        rd(8'h14, v, irq_s);
        exp_state = next_word(exp_state);
        chk(req, v, exp_state);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd11));
        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(1);
        // R1 reset state
        rd(8'h0C, v, irq_s); chk("R1 status", v, 0); chk("R1 irq", 32'(irq_s), 0);
        rd(8'h10, v, irq_s); chk("R1 error", v, 0);
        rd(8'h08, v, irq_s); chk("R1 control", v, 0);
        // R2 map and readback
        rd(8'h04, v, irq_s); chk("R2 cmd reads 0", v, 0);
        rd(8'h18, v, irq_s); chk("R2 unmapped", v, 0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v, irq_s); chk("R2 ctrl mask bits", v, 32'h60);
        wr(8'h08, 0);
        // R11 empty read
        rd(8'h14, v, irq_s); chk("R11 empty data", v, 0);
        rd(8'h0C, v, irq_s); chk("R11 status err, level 0", v, 32'h1_0000);
        chk("R8 error irq", 32'(irq_s), 1);
        rd(8'h10, v, irq_s); chk("R11 error bit2", v, 32'h4);
        wr(8'h08, 32'h40);
        rd(8'h0C, v, irq_s); chk("R8 error masked", 32'(irq_s), 0);
        wr(8'h08, 0);
        wr(8'h04, 32'h10);
        rd(8'h10, v, irq_s); chk("R6 clr_int keeps error", v, 32'h4);
        chk("R6 irq stays", 32'(irq_s), 1);
        wr(8'h04, 32'h20);
        rd(8'h10, v, irq_s); chk("R7 error cleared", v, 0); chk("R7 irq low", 32'(irq_s), 0);
        // R3 self-test timing
        wr(8'h04, 32'h1);
        idle(TEST_CYC - 1);
        rd(8'h0C, v, irq_s); chk("R3 not yet done", v, 0);
        rd(8'h0C, v, irq_s); chk("R3 test done", v, 32'h10); chk("R3 irq", 32'(irq_s), 1);
        wr(8'h04, 32'h10);
        rd(8'h0C, v, irq_s); chk("R6 clr_int clean", v, 0); chk("R6 irq low", 32'(irq_s), 0);
        // R3 masked done
        wr(8'h08, 32'h20);
        wr(8'h04, 32'h1);
        idle(TEST_CYC + 2);
        rd(8'h0C, v, irq_s); chk("R3 masked status", v, 32'h10); chk("R3 masked irq", 32'(irq_s), 0);
        wr(8'h04, 32'h10); wr(8'h08, 0);
        // R5 ignored command, R4 failing seed
        inj = 1'b1;
        wr(8'h04, 32'h2);
        wr(8'h04, 32'h1);
        idle(SEED_CYC + TEST_CYC + 20);
        inj = 1'b0;
        rd(8'h0C, v, irq_s);
        chk("R5 R4 status (no test done, seed done, err, level 0)", v, 32'h1_0020);
        rd(8'h10, v, irq_s); chk("R4 stat code", v, 32'h8);
        wr(8'h04, 32'h10);
        rd(8'h10, v, irq_s); chk("R6 clr_int ignored on error", v, 32'h8);
        wr(8'h04, 32'h20);
        rd(8'h0C, v, irq_s); chk("R7 cleared", v, 0);
        // R9 clean retry
        wr(8'h04, 32'h2);
        idle(SEED_CYC + 20);
        rd(8'h0C, v, irq_s); chk("R9 full, seed done", v, 32'h0F20);
        wr(8'h04, 32'h10);
        // R10 pop from full
        pop_expect("R10 first word");
        rd(8'h0C, v, irq_s); chk("R10 level 14", v, 32'h0E00);
        rd(8'h0C, v, irq_s); chk("R9 refill 15", v, 32'h0F00);
        // R12 error halts generation
        inj = 1'b1;
        wr(8'h04, 32'h2);
        idle(SEED_CYC + 2);
        inj = 1'b0;
        for (int i = 0; i < 15; i++) pop_expect("R12 R10 drain under error");
        idle(10);
        rd(8'h0C, v, irq_s); chk("R12 halted", v, 32'h1_0020);
        wr(8'h04, 32'h20);
        idle(20);
        rd(8'h0C, v, irq_s); chk("R12 resumed", v, 32'h0F00);
        // random phase
        for (int i = 0; i < 300; i++) begin
            idle($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) begin
                logic [31:0] c = $urandom() & 32'hFFFF_FF9F;
                wr(8'h08, c);
                rd(8'h08, v, irq_s); chk("R2 random ctrl", v, 32'h0);
            end
            rd(8'h0C, v, irq_s);
            chk("R9 level bound", 32'(v[11:8] <= 4'd15 && v[16] == 1'b0), 1);
            if (v[11:8] != 0) pop_expect("R10 random pop");
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule